// File: doc/BRIEF.md
# Baud Prescaler Control

This block holds an 8-bit control byte for a UART's baud timing and turns the system clock into a slow strobe, `tick`. A downstream baud counter advances once per tick. Software writes the byte through a single-cycle write strobe. One bit enables or stops the whole serial timing path. Two bits choose one of four clock divisors, and their encoding does not follow the order of the divisor sizes. The remaining bits are reserved and always read back as zero.

While the block is enabled, it counts system clocks and raises `tick` for one clock at the end of each interval of N clocks. With the divide-by-1 setting, `tick` stays high on every clock. Stopping the block clears the count. Choosing a new divisor while running starts a fresh interval, so no interval of the wrong length ever appears on the output. The block does not contain the baud reload counter or the serial shifters.

Top module: `baud_prescale_ctrl`

## Requirements
- R1: While the enable bit (bit 6) reads 0, `tick` is low on every clock, starting one clock after the bit is seen cleared.
- R2: A write with `wr_en` high stores bit 6 and bits 1..0 of `wr_data`. From the clock after the write edge, `rd_data` shows those bits in the same positions.
- R3: Bit 7 and bits 5..2 of `rd_data` always read 0, whatever value was written.
- R4: After reset, `rd_data` is 0x00 and `tick` is low. The block is stopped, with select code 00 (divide-by-12).
- R5: Select codes map to divisors as follows: 00 gives 12, 01 gives 4, 10 gives 48 and 11 gives 1. While enabled, `tick` is high for exactly one clock in every N. With divisor 1, `tick` is high on every clock.
- R6: After a write that sets the enable bit, the first tick is high in the clock cycle N rising edges after the write edge, where N is the divisor selected by that write.
- R7: A write that clears the enable bit returns the count to zero. A later write that sets the bit again gives a full first interval of N clocks.
- R8: A write that changes the select code while enabled restarts the count. The first tick under the new setting is high N_new rising edges after the write edge.
- R9: A write that leaves bit 6 and bits 1..0 unchanged does not disturb the tick phase. This holds even when the reserved bits of the written value differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value to write into the control byte |
| rd_data | output | 8 | Current control byte, with reserved bits forced to 0 |
| tick | output | 1 | Registered single-clock strobe, one per divisor interval |

## Verification
The bench counts rising edges and takes the edge that registers a write as edge S. The control byte must appear on `rd_data` in cycle S, and the bench compares it at the falling edge of that cycle. After a write that enables the block or changes the select code, the tick is due in cycles S+N, S+2N and so on. After a write that stops the block, `tick` keeps its previous schedule for cycle S only and is low from cycle S+1 onwards. The driver task records each write's edge number and updates the expected tick schedule. It also queues the expected readback value. The monitor samples at every falling edge and compares `tick` against that schedule on every cycle, so an early or late tick fails in the exact cycle it occurs.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int REG_W   = 8;
  localparam int SEL_W   = 2;
  localparam int RUN_POS = 6;

  typedef enum logic [SEL_W-1:0] {
    PS_DIV12 = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV48 = 2'b10,
    PS_DIV1  = 2'b11
  } psel_e;

  typedef struct packed {
    logic  run;
    psel_e sel;
  } ctrl_s;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/bpc_ctrl_reg.sv
module bpc_ctrl_reg
  import baud_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int EN_POS = RUN_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_s             ctrl_q,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.run <= 1'b0;
      ctrl_q.sel <= PS_DIV12;
    end else if (wr_en) begin
      ctrl_q.run <= wr_data[EN_POS];
      ctrl_q.sel <= psel_e'(wr_data[SEL_W-1:0]);
    end
  end

  // Readback built bit by bit: only the enable and select fields are live.
  for (genvar b = 0; b < DATA_W; b++) begin : g_rd
    if (b == EN_POS) begin : g_run
      assign rd_data[b] = ctrl_q.run;
    end else if (b < SEL_W) begin : g_sel
      assign rd_data[b] = ctrl_q.sel[b];
    end else begin : g_rsv
      assign rd_data[b] = 1'b0;
    end
  end

endmodule

// File: rtl/bpc_div_lut.sv
module bpc_div_lut
  import baud_pkg::*;
#(
  parameter int DIV_C0 = 12,
  parameter int DIV_C1 = 4,
  parameter int DIV_C2 = 48,
  parameter int DIV_C3 = 1,
  parameter int CNT_W  = 6
) (
  input  psel_e            sel,
  output logic [CNT_W-1:0] term
);

  localparam logic [CNT_W-1:0] T0 = CNT_W'(DIV_C0 - 1);
  localparam logic [CNT_W-1:0] T1 = CNT_W'(DIV_C1 - 1);
  localparam logic [CNT_W-1:0] T2 = CNT_W'(DIV_C2 - 1);
  localparam logic [CNT_W-1:0] T3 = CNT_W'(DIV_C3 - 1);

  always_comb begin
    unique case (sel)
      PS_DIV12: term = T0;
      PS_DIV4:  term = T1;
      PS_DIV48: term = T2;
      PS_DIV1:  term = T3;
      default:  term = T0;
    endcase
  end

endmodule

// File: rtl/bpc_prescaler.sv
module bpc_prescaler
  import baud_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  psel_e            sel,
  input  logic [CNT_W-1:0] term,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_eff;
  psel_e            sel_seen;
  logic             restart;

  // A select change seen one cycle late restarts the interval from zero.
  assign restart = (sel != sel_seen);
  assign cnt_eff = restart ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      tick     <= 1'b0;
      sel_seen <= PS_DIV12;
    end else begin
      sel_seen <= sel;
      if (!run) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (cnt_eff == term) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt_eff + 1'b1;
        tick <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/baud_prescale_ctrl.sv
module baud_prescale_ctrl
  import baud_pkg::*;
#(
  parameter int DIV_C0 = 12,
  parameter int DIV_C1 = 4,
  parameter int DIV_C2 = 48,
  parameter int DIV_C3 = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             tick
);

  localparam int DIV_MAX = max4(DIV_C0, DIV_C1, DIV_C2, DIV_C3);
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  ctrl_s            ctrl_q;
  logic [CNT_W-1:0] term;

  bpc_ctrl_reg #(
    .DATA_W (REG_W),
    .EN_POS (RUN_POS)
  ) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .rd_data (rd_data)
  );

  bpc_div_lut #(
    .DIV_C0 (DIV_C0),
    .DIV_C1 (DIV_C1),
    .DIV_C2 (DIV_C2),
    .DIV_C3 (DIV_C3),
    .CNT_W  (CNT_W)
  ) u_lut (
    .sel  (ctrl_q.sel),
    .term (term)
  );

  bpc_prescaler #(
    .CNT_W (CNT_W)
  ) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q.run),
    .sel  (ctrl_q.sel),
    .term (term),
    .tick (tick)
  );

endmodule

// File: rtl/baud_prescale_ctrl_chk.sv
module baud_prescale_ctrl_chk
  import baud_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             tick
);

  localparam logic [REG_W-1:0] LIVE = REG_W'((1 << RUN_POS) | ((1 << SEL_W) - 1));

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_STATE: assert (rd_data == '0 && !tick); // R4
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE) == '0); // R3

  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & LIVE)); // R2

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd_data[RUN_POS] |=> !tick); // R1

  AST_DIV1_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (rd_data[RUN_POS] && rd_data[SEL_W-1:0] == 2'b11) |=> tick); // R5

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (tick && rd_data[SEL_W-1:0] != 2'b11) |=> !tick); // R5

endmodule

bind baud_prescale_ctrl baud_prescale_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .tick    (tick)
);

// File: tb/baud_prescale_ctrl_tb.sv
module baud_prescale_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       tick;

  baud_prescale_ctrl u_dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tick    (tick)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0;
  int    errors = 0;
  string req = "R4";
  bit    mon_on = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] val;
    string      tag;
  } rb_t;
  rb_t rbq[$];

  typedef struct {
    bit run;
    int n;
    int start;
  } sch_t;
  sch_t old_s = '{1'b0, 12, 0};
  sch_t cur_s = '{1'b0, 12, 0};
  int   new_from = 0;

  function automatic int divof(input logic [1:0] code);
    case (code)
      2'b00:   return 12;
      2'b01:   return 4;
      2'b10:   return 48;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // Driver: one register write, expected readback queued, tick schedule updated.
  task automatic wr(input logic [7:0] v, input logic [7:0] exp_rb, input string tag);
    bit r;
    int n;
    r = v[6];
    n = divof(v[1:0]);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    rbq.push_back('{cyc, exp_rb, tag});
    if (r != cur_s.run || n != cur_s.n) begin
      old_s    = cur_s;
      cur_s    = '{r, n, cyc};
      new_from = cyc + 1;
    end
  endtask

  // Monitor: compare tick each cycle and pop readback items when due.
  always @(negedge clk) begin : mon
    sch_t s;
    bit   e;
    rb_t  it;
    if (mon_on) begin
      s = (cyc < new_from) ? old_s : cur_s;
      e = s.run && (cyc >= s.start + s.n) && (((cyc - s.start) % s.n) == 0);
      check(req, {7'b0, tick}, {7'b0, e});
      if (rbq.size() > 0 && rbq[0].due <= cyc) begin
        it = rbq.pop_front();
        check(it.tag, rd_data, it.val);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4", rd_data, 8'h00);
    check("R4", {7'b0, tick}, 8'h00);
    mon_on = 1'b1;
    req = "R4";
    repeat (5) @(posedge clk);

    wr(8'hFF, 8'h43, "R3");
    req = "R5";
    repeat (6) @(posedge clk);

    wr(8'h40, 8'h40, "R2");
    req = "R8";
    repeat (30) @(posedge clk);

    wr(8'h41, 8'h41, "R2");
    req = "R8";
    repeat (9) @(posedge clk);
    @(negedge clk);
    while (!tick) @(negedge clk);
    wr(8'hC1, 8'h41, "R9");
    req = "R9";
    repeat (20) @(posedge clk);

    wr(8'h02, 8'h02, "R7");
    req = "R1";
    repeat (60) @(posedge clk);

    wr(8'h42, 8'h42, "R6");
    req = "R6";
    repeat (150) @(posedge clk);

    wr(8'h01, 8'h01, "R7");
    req = "R7";
    repeat (5) @(posedge clk);
    wr(8'h41, 8'h41, "R6");
    req = "R6";
    repeat (20) @(posedge clk);

    wr(8'hBC, 8'h00, "R3");
    req = "R1";
    repeat (10) @(posedge clk);

    wr(8'hFD, 8'h41, "R3");
    req = "R5";
    repeat (20) @(posedge clk);

    @(negedge clk);
    mon_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule